// File: doc/BRIEF.md
# Touch Key Detection Integrator

This block makes the touch/no-touch decision for a bank of capacitive keys. An acquisition front end supplies one measurement per slot. Each measurement carries a key index, the new signal level and that key's current baseline. The block tests whether the level has dropped below the baseline by at least the key's threshold. It then debounces that test with a per-key run counter, so a key is reported touched only after a programmed number of consecutive qualifying measurements. Release is debounced the same way.

A key that stays touched for too long is treated as stuck. Time is counted in units of 160 ticks of an external millisecond tick. When the limit expires, the block asks for a recalibration, either of the stuck key alone or of the whole bank, as chosen by a configuration input. An external calibrate strobe forces a bank-wide recalibration at any time. Every key included in a recalibration has its status and debounce state cleared, and it is reported again only once it requalifies.

Top module: `tki_detect`

## Requirements
- R1: A measurement qualifies as a touch when `smp_base` exceeds `smp_level` by at least the key's threshold (`cfg_thresh` byte k, unsigned).
- R2: A threshold setting of 0 behaves as 1, so a level equal to the baseline never qualifies.
- R3: A released key becomes touched after N consecutive qualifying measurements of that key, where N is its `cfg_integ` byte and values 0 and 1 act as 2. Any non-qualifying measurement restarts the run. Measurements of other keys do not affect the run.
- R4: A touched key is released only after N consecutive non-qualifying measurements, with the same N. A qualifying measurement restarts the release run.
- R5: While `cfg_maxon` is nonzero, a key that stays touched for `cfg_maxon`*160 `ms_tick` pulses raises `recal_req` for one cycle on the following clock. A `cfg_maxon` of 0 never raises it.
- R6: On a timeout with `cfg_recal_one`=1, `recal_mask` holds only the timed-out keys and the other keys keep their status. With `cfg_recal_one`=0, the mask holds all keys and every status clears.
- R7: A `cal_strobe` pulse makes the next cycle show `recal_req`=1, an all-ones `recal_mask` and every status clear. It also discards partial debounce runs.
- R8: A key cleared by recalibration stays released until N fresh qualifying measurements arrive.
- R9: A measurement whose `smp_key` is not below the key count changes no key state.
- R10: After reset all statuses are 0, `recal_req` is 0 and `recal_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A measurement is present this cycle |
| smp_key | input | 3 | Key index of the measurement |
| smp_level | input | 16 | Measured signal |
| smp_base | input | 16 | Baseline of that key |
| cfg_thresh | input | 56 | Per-key threshold, byte k for key k |
| cfg_integ | input | 56 | Per-key consecutive-sample count, byte k for key k |
| cfg_maxon | input | 8 | Stuck-key limit in 160-tick units, 0 disables |
| cfg_recal_one | input | 1 | 1: recalibrate only timed-out keys, 0: all keys |
| ms_tick | input | 1 | Millisecond time base pulse |
| cal_strobe | input | 1 | Request a bank-wide recalibration |
| key_status | output | 7 | Debounced touched flag per key |
| recal_req | output | 1 | One-cycle recalibration request |
| recal_mask | output | 7 | Keys included in the request |

## Verification
A corrupted run counter would surface at `key_status` as a key that flips one measurement early or late, or one that is held by a measurement meant for another key. The bench's per-sample model catches this at the first measurement of that key after the fault. A corrupted stuck timer surfaces as a `recal_req` whose cycle differs from the exact count of 160 ticks per unit, or as a mask that names the wrong keys. Stale state after a recalibration shows up as a key that reasserts after fewer than N fresh measurements.

// File: rtl/tki_pkg.sv
package tki_pkg;
   typedef enum logic {
      LANE_RELEASED = 1'b0,
      LANE_TOUCHED  = 1'b1
   } lane_state_e;

   localparam int unsigned RUN_FLOOR    = 2;
   localparam int unsigned THRESH_FLOOR = 1;
endpackage

// File: rtl/tki_qualify.sv
module tki_qualify #(
   parameter int unsigned SIG_W = 16,
   parameter int unsigned THR_W = 8
) (
   input  logic [SIG_W-1:0] level,
   input  logic [SIG_W-1:0] base,
   input  logic [THR_W-1:0] thresh,
   output logic             qual
);
   import tki_pkg::*;

   logic [SIG_W:0]   drop;
   logic [SIG_W-1:0] need;

   generate
      if (THR_W > SIG_W) begin : g_bad_width
         $error("tki_qualify: THR_W must not exceed SIG_W");
      end
   endgenerate

   always_comb begin
      drop = {1'b0, base} - {1'b0, level};
      need = (thresh < THR_W'(THRESH_FLOOR)) ? SIG_W'(THRESH_FLOOR) : SIG_W'(thresh);
      qual = !drop[SIG_W] && (drop[SIG_W-1:0] >= need);
   end

   // R2: an unchanged level can never qualify
   always_comb begin
      if (level == base) begin
         a_equal_never_r2 : assert (!qual);
      end
   end
endmodule

// File: rtl/tki_key_lane.sv
module tki_key_lane #(
   parameter int unsigned DI_W    = 8,
   parameter int unsigned TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_hit,
   input  logic               qual,
   input  logic [DI_W-1:0]    di_set,
   input  logic               ms_tick,
   input  logic [TIMER_W-1:0] limit,
   input  logic               limit_en,
   input  logic               clear,
   output logic               status,
   output logic               timeout
);
   import tki_pkg::*;

   lane_state_e        st;
   logic [DI_W:0]      run;
   logic [DI_W:0]      run_nxt;
   logic [DI_W:0]      need;
   logic [TIMER_W-1:0] timer;
   logic               agree;

   always_comb begin
      need    = ({1'b0, di_set} < (DI_W+1)'(RUN_FLOOR)) ? (DI_W+1)'(RUN_FLOOR) : {1'b0, di_set};
      agree   = (st == LANE_TOUCHED) ? !qual : qual;
      run_nxt = run + 1'b1;
      status  = (st == LANE_TOUCHED);
      timeout = (st == LANE_TOUCHED) && limit_en && (timer >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= LANE_RELEASED;
         run   <= '0;
         timer <= '0;
      end else if (clear) begin
         st    <= LANE_RELEASED;
         run   <= '0;
         timer <= '0;
      end else begin
         if (sample_hit) begin
            if (!agree) begin
               run <= '0;
            end else if (run_nxt >= need) begin
               st  <= (st == LANE_TOUCHED) ? LANE_RELEASED : LANE_TOUCHED;
               run <= '0;
            end else begin
               run <= run_nxt;
            end
         end
         if (st != LANE_TOUCHED) begin
            timer <= '0;
         end else if (ms_tick && (timer != '1)) begin
            timer <= timer + 1'b1;
         end
      end
   end

   // R3/R4: status moves only on a measurement of this key or a clear
   p_status_moves_on_sample_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> ($past(sample_hit) || $past(clear)));

   // R8: a cleared lane comes out released
   p_clear_releases_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !status);

   // R5: the stuck timer never runs while the key is released
   p_timer_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!status && !$past(status)) |-> (timer == '0));
endmodule

// File: rtl/tki_detect.sv
module tki_detect #(
   parameter int unsigned NKEYS      = 7,
   parameter int unsigned SIG_W      = 16,
   parameter int unsigned THR_W      = 8,
   parameter int unsigned DI_W       = 8,
   parameter int unsigned MAXON_W    = 8,
   parameter int unsigned UNIT_TICKS = 160,
   localparam int unsigned KEY_IDX_W = (NKEYS > 1) ? $clog2(NKEYS) : 1,
   localparam int unsigned TIMER_W   = $clog2(((1 << MAXON_W) - 1) * UNIT_TICKS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic [KEY_IDX_W-1:0]   smp_key,
   input  logic [SIG_W-1:0]       smp_level,
   input  logic [SIG_W-1:0]       smp_base,
   input  logic [NKEYS*THR_W-1:0] cfg_thresh,
   input  logic [NKEYS*DI_W-1:0]  cfg_integ,
   input  logic [MAXON_W-1:0]     cfg_maxon,
   input  logic                   cfg_recal_one,
   input  logic                   ms_tick,
   input  logic                   cal_strobe,
   output logic [NKEYS-1:0]       key_status,
   output logic                   recal_req,
   output logic [NKEYS-1:0]       recal_mask
);
   logic [THR_W-1:0]   sel_thr;
   logic [NKEYS-1:0]   hit_vec;
   logic [NKEYS-1:0]   timeout_vec;
   logic [NKEYS-1:0]   clear_vec;
   logic [TIMER_W-1:0] limit;
   logic               qual;

   generate
      if (NKEYS < 1 || NKEYS > 16) begin : g_bad_keys
         $error("tki_detect: NKEYS must be 1..16");
      end
      if (UNIT_TICKS < 1) begin : g_bad_unit
         $error("tki_detect: UNIT_TICKS must be at least 1");
      end
      if (DI_W < 2) begin : g_bad_di
         $error("tki_detect: DI_W must be at least 2");
      end
   endgenerate

   always_comb begin
      sel_thr = '0;
      hit_vec = '0;
      for (int k = 0; k < NKEYS; k++) begin
         if (smp_key == KEY_IDX_W'(k)) begin
            sel_thr    = cfg_thresh[k*THR_W +: THR_W];
            hit_vec[k] = smp_valid;
         end
      end
      limit = TIMER_W'(cfg_maxon) * TIMER_W'(UNIT_TICKS);
   end

   tki_qualify #(.SIG_W(SIG_W), .THR_W(THR_W)) i_qualify (
      .level  (smp_level),
      .base   (smp_base),
      .thresh (sel_thr),
      .qual   (qual)
   );

   generate
      for (genvar k = 0; k < NKEYS; k++) begin : g_lane
         tki_key_lane #(.DI_W(DI_W), .TIMER_W(TIMER_W)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_hit (hit_vec[k]),
            .qual       (qual),
            .di_set     (cfg_integ[k*DI_W +: DI_W]),
            .ms_tick    (ms_tick),
            .limit      (limit),
            .limit_en   (cfg_maxon != '0),
            .clear      (clear_vec[k]),
            .status     (key_status[k]),
            .timeout    (timeout_vec[k])
         );
      end
   endgenerate

   always_comb begin
      if (cal_strobe) begin
         clear_vec = '1;
      end else if (timeout_vec != '0) begin
         clear_vec = cfg_recal_one ? timeout_vec : '1;
      end else begin
         clear_vec = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recal_req  <= 1'b0;
         recal_mask <= '0;
      end else begin
         recal_req  <= (clear_vec != '0);
         recal_mask <= clear_vec;
      end
   end

   // R6: a request always names keys, and no request carries a mask
   p_mask_matches_req_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      recal_req == (recal_mask != '0));

   // R6: every key named in a request comes out released
   p_recal_releases_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      recal_req |-> ((key_status & recal_mask) == '0));

   // R6: single-key mode only names keys that were touched
   p_single_mask_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (recal_req && $past(cfg_recal_one) && !$past(cal_strobe))
      |-> ((recal_mask & ~$past(key_status)) == '0));

   // R7: a calibrate strobe yields a full-bank request
   p_cal_full_bank_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(cal_strobe) |-> (recal_req && (recal_mask == '1) && (key_status == '0)));

   // R5: a disabled limit never produces a timeout request
   p_limit_off_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_maxon) == '0 && !$past(cal_strobe)) |-> !recal_req);
endmodule

// File: tb/test_tki_detect.sv
`timescale 1ns/1ps
module test_tki_detect;
   localparam int NK = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [2:0]    smp_key = '0;
   logic [15:0]   smp_level = '0;
   logic [15:0]   smp_base = '0;
   logic [NK*8-1:0] cfg_thresh = '0;
   logic [NK*8-1:0] cfg_integ = '0;
   logic [7:0]    cfg_maxon = '0;
   logic          cfg_recal_one = 1'b0;
   logic          ms_tick = 1'b0;
   logic          cal_strobe = 1'b0;
   logic [NK-1:0] key_status;
   logic          recal_req;
   logic [NK-1:0] recal_mask;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int m_run [NK];
   bit m_st  [NK];

   always #2 clk = ~clk;

   tki_detect i_tki_detect (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_key(smp_key),
      .smp_level(smp_level), .smp_base(smp_base), .cfg_thresh(cfg_thresh),
      .cfg_integ(cfg_integ), .cfg_maxon(cfg_maxon), .cfg_recal_one(cfg_recal_one),
      .ms_tick(ms_tick), .cal_strobe(cal_strobe), .key_status(key_status),
      .recal_req(recal_req), .recal_mask(recal_mask)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit f_qual(input int level, input int base, input int thr);
      int t;
      t = (thr == 0) ? 1 : thr;
      return (base > level) && ((base - level) >= t);
   endfunction

   function automatic int f_need(input int di);
      return (di < 2) ? 2 : di;
   endfunction

   task automatic set_key(input int k, input int thr, input int di);
      cfg_thresh[k*8 +: 8] = 8'(thr);
      cfg_integ[k*8 +: 8]  = 8'(di);
   endtask

   // one measurement, consumes one rising edge, returns at a falling edge
   task automatic send(input int k, input int level, input int base);
      smp_valid = 1'b1;
      smp_key   = 3'(k);
      smp_level = 16'(level);
      smp_base  = 16'(base);
      @(posedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic model_step(input int k, input int level, input int base);
      bit q, agree;
      if (k >= NK) return;
      q = f_qual(level, base, cfg_thresh[k*8 +: 8]);
      agree = m_st[k] ? !q : q;
      if (!agree) m_run[k] = 0;
      else if (m_run[k] + 1 >= f_need(cfg_integ[k*8 +: 8])) begin
         m_st[k] = !m_st[k];
         m_run[k] = 0;
      end else m_run[k]++;
   endtask

   task automatic pulse_cal();
      cal_strobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cal_strobe = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_7a11));
      for (int k = 0; k < NK; k++) begin
         m_run[k] = 0;
         m_st[k] = 0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(key_status, 0, "R10 status after reset");
      chk(recal_req, 0, "R10 req after reset");
      chk(recal_mask, 0, "R10 mask after reset");
      rst_n = 1'b1;
      @(negedge clk);

      // random phase, limit disabled
      for (int k = 0; k < NK; k++) set_key(k, $urandom_range(0, 6), $urandom_range(0, 4));
      cfg_maxon = 0;
      for (int i = 0; i < 800; i++) begin
         int k, base, level;
         bit any_req;
         k = $urandom_range(0, 7);
         base = $urandom_range(1000, 1100);
         level = base - $urandom_range(0, 9) + $urandom_range(0, 2);
         ms_tick = 1'($urandom_range(0, 1));
         any_req = 0;
         send(k, level, base);
         model_step(k, level, base);
         for (int j = 0; j < NK; j++)
            chk(key_status[j], m_st[j], "R1 R3 R4 R9 random status");
         chk(recal_req, 0, "R5 no request with limit zero");
      end

      // R7: calibrate clears everything and discards partial runs
      pulse_cal();
      chk(recal_req, 1, "R7 req after strobe");
      chk(recal_mask, 7'h7F, "R7 mask after strobe");
      chk(key_status, 0, "R7 status after strobe");
      @(negedge clk);
      chk(recal_req, 0, "R7 req one cycle");
      ms_tick = 1'b0;
      for (int k = 0; k < NK; k++) set_key(k, 5, 2);
      send(0, 95, 100);
      pulse_cal();
      send(0, 95, 100);
      chk(key_status[0], 0, "R7 partial run discarded");
      send(0, 95, 100);
      chk(key_status[0], 1, "R7 key detects after fresh run");
      pulse_cal();

      // R1: exact threshold boundary
      set_key(1, 5, 2);
      send(1, 96, 100); send(1, 96, 100);
      chk(key_status[1], 0, "R1 drop below threshold");
      send(1, 95, 100); send(1, 95, 100);
      chk(key_status[1], 1, "R1 drop equal to threshold");
      pulse_cal();

      // R2: threshold zero acts as one
      set_key(0, 0, 2);
      send(0, 100, 100); send(0, 100, 100); send(0, 100, 100);
      chk(key_status[0], 0, "R2 equal level never detects");
      send(0, 99, 100); send(0, 99, 100);
      chk(key_status[0], 1, "R2 drop of one detects");
      pulse_cal();

      // R3: setting 1 behaves as 2, non-qualifying restarts, other keys ignored
      set_key(1, 4, 1);
      send(1, 90, 100);
      chk(key_status[1], 0, "R3 one sample not enough");
      send(2, 90, 100);
      send(1, 90, 100);
      chk(key_status[1], 1, "R3 second sample detects across other key");
      pulse_cal();
      set_key(1, 4, 0);
      send(1, 90, 100); send(1, 99, 100); send(1, 90, 100);
      chk(key_status[1], 0, "R3 broken run restarts");
      send(1, 90, 100);
      chk(key_status[1], 1, "R3 run completes");
      // R4: release needs the same run
      send(1, 99, 100);
      chk(key_status[1], 1, "R4 one release sample not enough");
      send(1, 90, 100); send(1, 99, 100);
      chk(key_status[1], 1, "R4 qualifying sample restarts release");
      send(1, 99, 100);
      chk(key_status[1], 0, "R4 release completes");
      pulse_cal();
      set_key(3, 4, 4);
      for (int i = 0; i < 3; i++) send(3, 80, 100);
      chk(key_status[3], 0, "R3 run of four needs four");
      send(3, 80, 100);
      chk(key_status[3], 1, "R3 fourth sample detects");
      pulse_cal();

      // R9: out-of-range index
      for (int i = 0; i < 4; i++) send(7, 10, 100);
      chk(key_status, 0, "R9 index seven ignored");

      // R5 R6: single-key timeout
      for (int k = 0; k < NK; k++) set_key(k, 5, 2);
      cfg_maxon = 1;
      cfg_recal_one = 1'b1;
      ms_tick = 1'b1;
      send(3, 80, 100); send(3, 80, 100);
      send(2, 80, 100); send(2, 80, 100);
      idle(158);
      chk(key_status[3], 1, "R5 key still touched at limit");
      chk(recal_req, 0, "R5 no early request");
      @(negedge clk);
      chk(recal_req, 1, "R5 request after limit");
      chk(recal_mask, 7'h08, "R6 single mask");
      chk(key_status, 7'h04, "R6 other key kept");
      @(negedge clk);
      chk(recal_req, 0, "R5 request one cycle");
      @(negedge clk);
      chk(recal_req, 1, "R5 second key times out");
      chk(recal_mask, 7'h04, "R6 second single mask");
      chk(key_status, 0, "R6 second key cleared");

      // R6 all-keys mode, R8 requalification
      cfg_recal_one = 1'b0;
      send(4, 80, 100); send(4, 80, 100);
      send(5, 80, 100); send(5, 80, 100);
      idle(158);
      @(negedge clk);
      chk(recal_req, 1, "R6 all-mode request");
      chk(recal_mask, 7'h7F, "R6 all-mode mask");
      chk(key_status, 0, "R6 all statuses cleared");
      send(5, 80, 100);
      chk(key_status[5], 0, "R8 held clear after one sample");
      send(5, 80, 100);
      chk(key_status[5], 1, "R8 requalifies after run");

      // R5: zero limit never times out
      pulse_cal();
      cfg_maxon = 0;
      send(6, 80, 100); send(6, 80, 100);
      idle(400);
      chk(key_status[6], 1, "R5 zero limit keeps key");
      chk(recal_req, 0, "R5 zero limit no request");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule